// File: doc/BRIEF.md
# Parallel EPROM Read-Cycle Controller

This block sits on the host side of a bank of 16-bit parallel EPROM devices and turns single-word read requests into correctly timed memory cycles. The host hands over a word address on a valid/ready request channel. The upper address bits pick one device, and the controller pulls that device's active-low chip enable low. It drives the lower bits onto the shared address bus. One active-low output enable is common to every device. The controller waits out the device access times, registers the data word and returns it with a one-cycle response strobe. It then keeps the bus quiet long enough for the released device to stop driving the data pins.

The wait times are given in picoseconds together with the clock period, and each one is rounded up to whole cycles. The data is valid only after the longest of three delays: address-to-data, chip-enable-to-data and output-enable-to-data. Address and chip enable go out together. The output enable follows after a lead time, chosen so that its shorter delay ends in the same cycle as the longest one. The data is registered in the same edge that raises both enables, because the devices guarantee no hold time after those signals change.

Back-pressure rules: `req_ready` is high exactly when the one-entry pending slot is empty. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must then hold `req_addr` steady only up to that edge. A request accepted while a cycle is in flight waits in the slot and is launched as soon as the float-off gap ends. The response channel has no ready: `rsp_valid` is a single-cycle strobe that the host must take when it comes.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it: every chip enable and the output enable are high (inactive), `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` equals "pending slot empty". A request accepted while a cycle is running is held and not lost. It is launched later, and requests complete in the order they were accepted.
- R3: On launch, `mem_addr` takes the lower `ADDR_W` bits of the request. The chip enable whose index equals the upper select field goes low (index 0 = `mem_ce_n[0]`). The output enable stays high.
- R4: The cycle counts are ACC, CE, OE and DF, and W is the largest of ACC, CE and OE. The output enable goes low exactly W−OE cycles after launch, or at launch when W equals OE.
- R5: Exactly W cycles after launch, `rsp_valid` is high for one cycle with the word from the data pins as sampled at that edge. All chip enables and the output enable go high in that same cycle.
- R6: The next launch comes no earlier than DF cycles after the release edge, and no earlier than one cycle after it. When a request is already pending, it launches exactly then.
- R7: A select field of NUM_DEV or more drives no chip enable but still runs the full timed cycle, and returns an all-ones word (the erased state).
- R8: At most one chip enable is low at any time, and the output enable is low only inside an access cycle.
- R9: Each count is the ceiling of its picosecond time divided by the clock period. At 5000 ps with 55000/62000/40000/30000 ps this gives ACC=11, CE=13, OE=8 and DF=6, so launch-to-response is 13 cycles.
- R10: `mem_addr` does not change while the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Pending slot empty; request taken this edge if valid |
| req_addr | input | ADDR_W+SEL_W | Word address: device select above, in-device address below |
| rsp_valid | output | 1 | One-cycle strobe: read data returned |
| rsp_data | output | DATA_W | Returned word |
| mem_addr | output | ADDR_W | Shared address bus to the devices |
| mem_ce_n | output | NUM_DEV | Per-device active-low chip enables |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq | input | DATA_W | Data pins from the devices |

## Verification
The bench builds the block with three devices, a 5000 ps clock and times of 55000, 62000, 40000 and 30000 ps. The chip-enable path is therefore the longest one, which checks that the wait comes from the maximum of all three delays and not from the address time alone. With three devices and a two-bit select field, select value 3 is an unmapped code, so the all-ones return for an address with no device is reachable. The bench's memory model puts correct data on the pins only once every delay has been met. A read sampled one edge early, or an output enable raised too late, therefore shows up as wrong data.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_WAIT = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_t;

  // round a time up to whole clock periods
  function automatic int ps_to_cycles(input int time_ps, input int clk_ps);
    return (time_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int sel_width(input int n_dev);
    return (n_dev > 1) ? $clog2(n_dev) : 1;
  endfunction

endpackage

// File: rtl/eprom_req_slot.sv
module eprom_req_slot #(
  parameter int HA_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HA_W-1:0] in_addr,
  input  logic            pop,
  output logic            pend_vld,
  output logic [HA_W-1:0] pend_addr
);

  logic            full_q;
  logic [HA_W-1:0] addr_q;

  assign in_ready  = ~full_q;
  assign pend_vld  = full_q;
  assign pend_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      addr_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      addr_q <= in_addr;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/eprom_access_seq.sv
module eprom_access_seq
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2,
  parameter int WAIT_C = 11,
  parameter int OE_C   = 8,
  parameter int DF_C   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pend_vld,
  input  logic [ADDR_W+SEL_W-1:0] pend_addr,
  output logic                    launch,
  output logic                    sample_now,
  output logic                    cyc_on,
  output logic                    oe_on,
  output logic [ADDR_W-1:0]       addr_q,
  output logic [SEL_W-1:0]        sel_q
);

  localparam int LEAD_C = WAIT_C - OE_C;
  localparam int TOP_C  = max3(WAIT_C, DF_C, 1);
  localparam int CNT_W  = $clog2(TOP_C + 1) + 1;

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_last;

  assign cnt_last   = (cnt_q == CNT_W'(1));
  assign launch     = pend_vld && ((st_q == SEQ_IDLE) || (st_q == SEQ_GAP && cnt_last));
  assign sample_now = (st_q == SEQ_WAIT) && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      cyc_on <= 1'b0;
      oe_on  <= 1'b0;
      addr_q <= '0;
      sel_q  <= '0;
    end else if (launch) begin
      addr_q <= pend_addr[ADDR_W-1:0];
      sel_q  <= pend_addr[ADDR_W+SEL_W-1:ADDR_W];
      cyc_on <= 1'b1;
      if (LEAD_C == 0) begin
        oe_on <= 1'b1;
        st_q  <= SEQ_WAIT;
        cnt_q <= CNT_W'(WAIT_C);
      end else begin
        st_q  <= SEQ_LEAD;
        cnt_q <= CNT_W'(LEAD_C);
      end
    end else begin
      unique case (st_q)
        SEQ_LEAD: begin
          if (cnt_last) begin
            oe_on <= 1'b1;
            st_q  <= SEQ_WAIT;
            cnt_q <= CNT_W'(OE_C);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        SEQ_WAIT: begin
          if (cnt_last) begin
            cyc_on <= 1'b0;
            oe_on  <= 1'b0;
            if (DF_C == 0) begin
              st_q <= SEQ_IDLE;
            end else begin
              st_q  <= SEQ_GAP;
              cnt_q <= CNT_W'(DF_C);
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        SEQ_GAP: begin
          if (cnt_last) st_q <= SEQ_IDLE;
          else          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eprom_cs_decode.sv
module eprom_cs_decode #(
  parameter int NUM_DEV = 4,
  parameter int SEL_W   = 2
) (
  input  logic               cyc_on,
  input  logic [SEL_W-1:0]   sel_q,
  output logic [NUM_DEV-1:0] ce_n,
  output logic               sel_hit
);

  assign sel_hit = ({1'b0, sel_q} < (SEL_W+1)'(NUM_DEV));

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_ce
    assign ce_n[d] = ~(cyc_on && (sel_q == SEL_W'(d)));
  end

endmodule

// File: rtl/eprom_data_capture.sv
module eprom_data_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_now,
  input  logic              sel_hit,
  input  logic [DATA_W-1:0] dq,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample_now;
      if (sample_now) rsp_data <= sel_hit ? dq : '1;
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CLK_PS  = 5000,
  parameter int ACC_PS  = 55000,
  parameter int CE_PS   = 55000,
  parameter int OE_PS   = 40000,
  parameter int DF_PS   = 30000,
  localparam int SEL_W  = sel_width(NUM_DEV),
  localparam int HA_W   = ADDR_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [HA_W-1:0]    req_addr,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [NUM_DEV-1:0] mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DATA_W-1:0]  mem_dq
);

  localparam int ACC_C  = ps_to_cycles(ACC_PS, CLK_PS);
  localparam int CE_C   = ps_to_cycles(CE_PS, CLK_PS);
  localparam int OE_C   = ps_to_cycles(OE_PS, CLK_PS);
  localparam int DF_C   = ps_to_cycles(DF_PS, CLK_PS);
  localparam int WAIT_C = max3(ACC_C, CE_C, OE_C);

  logic             pend_vld;
  logic [HA_W-1:0]  pend_addr;
  logic             launch;
  logic             sample_now;
  logic             cyc_on;
  logic             oe_on;
  logic [SEL_W-1:0] sel_q;
  logic             sel_hit;

  eprom_req_slot #(.HA_W(HA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (req_addr),
    .pop       (launch),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr)
  );

  eprom_access_seq #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W),
    .WAIT_C (WAIT_C),
    .OE_C   (OE_C),
    .DF_C   (DF_C)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_vld   (pend_vld),
    .pend_addr  (pend_addr),
    .launch     (launch),
    .sample_now (sample_now),
    .cyc_on     (cyc_on),
    .oe_on      (oe_on),
    .addr_q     (mem_addr),
    .sel_q      (sel_q)
  );

  eprom_cs_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_dec (
    .cyc_on  (cyc_on),
    .sel_q   (sel_q),
    .ce_n    (mem_ce_n),
    .sel_hit (sel_hit)
  );

  eprom_data_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_now (sample_now),
    .sel_hit    (sel_hit),
    .dq         (mem_dq),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  assign mem_oe_n = ~oe_on;

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk
  import eprom_rd_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 16,
  parameter int HA_W    = 18,
  parameter int CLK_PS  = 5000,
  parameter int ACC_PS  = 55000,
  parameter int CE_PS   = 55000,
  parameter int OE_PS   = 40000,
  parameter int DF_PS   = 30000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [NUM_DEV-1:0] mem_ce_n,
  input logic               mem_oe_n
);

  localparam int OE_C   = ps_to_cycles(OE_PS, CLK_PS);
  localparam int DF_C   = ps_to_cycles(DF_PS, CLK_PS);
  localparam int WAIT_C = max3(ps_to_cycles(ACC_PS, CLK_PS), ps_to_cycles(CE_PS, CLK_PS), OE_C);
  localparam int LEAD_C = WAIT_C - OE_C;
  localparam int SAT    = 1 << 20;

  int since_rel;

  // cycles elapsed since the last release (response strobe)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rel <= SAT;
    else if (rsp_valid)        since_rel <= 0;
    else if (since_rel < SAT)  since_rel <= since_rel + 1;
  end

  assert_single_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n) <= 1);

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_release_at_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&mem_ce_n && mem_oe_n));

  assert_oe_before_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  assert_ready_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_float_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (since_rel + 1 >= DF_C + LEAD_C));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
  .NUM_DEV (NUM_DEV),
  .ADDR_W  (ADDR_W),
  .HA_W    (HA_W),
  .CLK_PS  (CLK_PS),
  .ACC_PS  (ACC_PS),
  .CE_PS   (CE_PS),
  .OE_PS   (OE_PS),
  .DF_PS   (DF_PS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_rd_ctrl;

  localparam int NUM_DEV = 3;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int HA_W    = ADDR_W + 2;
  localparam int CLK_PS  = 5000;
  localparam int ACC_PS  = 55000;
  localparam int CE_PS   = 62000;
  localparam int OE_PS   = 40000;
  localparam int DF_PS   = 30000;
  localparam int ACC_C   = (ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int CE_C    = (CE_PS + CLK_PS - 1) / CLK_PS;
  localparam int OE_C    = (OE_PS + CLK_PS - 1) / CLK_PS;
  localparam int DF_C    = (DF_PS + CLK_PS - 1) / CLK_PS;
  localparam int W_C     = (CE_C > ACC_C) ? ((CE_C > OE_C) ? CE_C : OE_C) : ((ACC_C > OE_C) ? ACC_C : OE_C);
  localparam int LEAD_C  = W_C - OE_C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [HA_W-1:0] req_addr = '0;
  logic req_ready;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [NUM_DEV-1:0] mem_ce_n;
  logic mem_oe_n;
  logic [DATA_W-1:0] mem_dq = '0;

  int n_chk = 0;
  int n_bad = 0;
  int ncyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eprom_rd_ctrl #(
    .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PS(CLK_PS),
    .ACC_PS(ACC_PS), .CE_PS(CE_PS), .OE_PS(OE_PS), .DF_PS(DF_PS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  function automatic logic [15:0] rom_word(input int dev, input logic [15:0] a);
    return a ^ 16'(dev * 16'h2F1B) ^ 16'hC35A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  // ---------------- reference model (updated on each rising edge) ----------
  int m_q[$];
  int m_t = -1;
  int m_gap = 0;
  int m_ce = -1;
  bit m_oe = 0;
  int m_addr = 0;
  int m_sel = 0;
  bit m_rsp = 0;
  int m_data = 0;
  bit m_ready = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_t = -1; m_gap = 0; m_ce = -1; m_oe = 0;
      m_addr = 0; m_sel = 0; m_rsp = 0; m_data = 0; m_ready = 1;
    end else begin
      int qn;
      bit idle_before;
      qn = m_q.size();
      idle_before = (m_t < 0);
      m_rsp = 0;
      if (m_t >= 0) begin
        m_t++;
        if (m_t == LEAD_C) m_oe = 1;
        if (m_t == W_C) begin
          m_rsp = 1;
          m_data = (m_sel < NUM_DEV) ? int'(rom_word(m_sel, 16'(m_addr))) : 16'hFFFF;
          m_ce = -1; m_oe = 0; m_t = -1; m_gap = DF_C;
        end
      end else if (idle_before) begin
        if (qn > 0 && m_gap <= 1) begin
          int a;
          a = m_q.pop_front();
          m_addr = a % 65536;
          m_sel = a / 65536;
          m_ce = (m_sel < NUM_DEV) ? m_sel : -1;
          m_t = 0;
          m_oe = (LEAD_C == 0);
          m_gap = 0;
        end else if (m_gap > 0) begin
          m_gap--;
        end
      end
      if (req_valid && qn == 0) m_q.push_back(int'(req_addr));
      m_ready = (m_q.size() == 0);
    end
  end

  // ---------------- device model and per-cycle compare (falling edge) ------
  logic [ADDR_W-1:0] p_addr = '0;
  logic [NUM_DEV-1:0] p_ce = '1;
  logic p_oe = 1'b1;
  int age_a = 0, age_c = 0, age_o = 0;
  int launch_n = -1, rsp_n = -1;
  bit seen_rsp = 0;

  always @(negedge clk) begin
    ncyc++;
    if (mem_addr != p_addr) age_a = 0; else age_a++;
    if (mem_ce_n != p_ce)   age_c = 0; else age_c++;
    if (mem_oe_n != p_oe)   age_o = 0; else age_o++;

    if (rst_n) begin
      // launch / release timing
      if (&p_ce && !(&mem_ce_n)) begin
        if (seen_rsp)
          check(ncyc - rsp_n >= DF_C, "R6 float gap", ncyc - rsp_n, DF_C);
        launch_n = ncyc;
      end
      if (rsp_valid) begin
        if (!(&p_ce)) begin
          check(ncyc - launch_n == 13, "R9 launch to response", ncyc - launch_n, 13);
        end
        rsp_n = ncyc; seen_rsp = 1;
      end
      check($countones(~mem_ce_n) <= 1, "R8 one chip enable", int'(mem_ce_n), 0);
      check(mem_oe_n || m_t >= 0 || m_rsp == 0, "R8 oe inside cycle", int'(mem_oe_n), 1);
      // compare against reference model
      for (int d = 0; d < NUM_DEV; d++)
        check(mem_ce_n[d] == (m_ce != d), "R3 chip enable", int'(mem_ce_n[d]), int'(m_ce != d));
      check(mem_oe_n == !m_oe, "R4 output enable", int'(mem_oe_n), int'(!m_oe));
      check(req_ready == m_ready, "R2 ready", int'(req_ready), int'(m_ready));
      check(rsp_valid == m_rsp, "R5 response strobe", int'(rsp_valid), int'(m_rsp));
      if (m_rsp) begin
        if (m_sel >= NUM_DEV) check(int'(rsp_data) == m_data, "R7 unmapped data", int'(rsp_data), m_data);
        else                  check(int'(rsp_data) == m_data, "R5 data", int'(rsp_data), m_data);
      end
      if (m_t >= 0 || m_rsp)
        check(int'(mem_addr) == m_addr, "R10 address", int'(mem_addr), m_addr);
    end

    // data pins: correct only once every delay has been met
    if (!mem_oe_n && $countones(~mem_ce_n) == 1 &&
        age_a + 1 >= ACC_C && age_c + 1 >= CE_C && age_o + 1 >= OE_C) begin
      int dv;
      dv = 0;
      for (int d = 0; d < NUM_DEV; d++) if (!mem_ce_n[d]) dv = d;
      mem_dq = rom_word(dv, mem_addr);
    end else begin
      mem_dq = 16'h1234 ^ mem_addr;
    end
    p_addr = mem_addr; p_ce = mem_ce_n; p_oe = mem_oe_n;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (ncyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", ncyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input int sel, input int a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = HA_W'(sel * 65536 + a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check(&mem_ce_n, "R1 ce reset", int'(mem_ce_n), 7);
    check(mem_oe_n == 1'b1, "R1 oe reset", int'(mem_oe_n), 1);
    check(rsp_valid == 1'b0, "R1 rsp reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1 ready reset", int'(req_ready), 1);
    rst_n = 1'b1;
    idle(1);
    check(&mem_ce_n && mem_oe_n && req_ready, "R1 after release", int'(mem_ce_n), 7);

    send(0, 16'h0010);               // R3 single read, device 0
    idle(30);
    send(2, 16'hFFFF);               // R3 top address, last device
    idle(30);
    send(3, 16'h0042);               // R7 unmapped select
    idle(30);
    send(1, 16'h0000);               // R2/R6 back-to-back burst
    send(1, 16'h0001);
    send(0, 16'hA5A5);
    send(2, 16'h7FFF);
    idle(80);
    send(3, 16'h0001);               // R7 unmapped followed by mapped
    send(1, 16'h1234);
    idle(60);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule